// File: doc/BRIEF.md
# LCD Shift Clock and Pixel Launch Generator

This block turns a module clock into the shift clock that an LCD panel uses to latch pixel data, and drives the panel's 18-lane data bus. A programmable divide field sets the pixel clock. In colour modes (active-matrix and passive colour) one pixel word leaves per shift clock. In monochrome mode a word carries 1, 2, 4 or 8 one-bit pixels, and the shift clock is slowed by that factor. Clock polarity and data polarity are set independently.

Pixel words arrive on a valid/ready stream. A word is taken only at the start of a shift period. The data bus changes on the inactive shift clock edge, so the panel sees roughly half a period of setup before the active edge and half a period of hold after it. Back-pressure: `pix_ready` is high only in the launch slot, which is one module clock per shift period. The source must hold `pix_valid` and `pix_data` unchanged until a cycle in which both `pix_valid` and `pix_ready` are high. When no word is offered, the clock parks at its inactive level and the bus holds its last value.

The configuration inputs are meant to change only while the block is idle or held in reset.

Top module: `lcd_shift_clk_gen`

## Requirements
- R1: Let base = `div_sel` + 1. In modes 0 (active-matrix colour) and 1 (passive colour), and in monochrome with `mono_width` = 0, the shift period P is base module clocks when words stream back to back.
- R2: In mode 2 (monochrome), `mono_width` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 lanes, and the shift period is base × lanes module clocks.
- R3: Each shift period holds the clock at its inactive level for floor(P/2) module clocks, starting at the launch edge, and at its active level for the remaining P − floor(P/2) clocks.
- R4: With `sclk_inv` = 0 the inactive level of `sclk` is 0. With `sclk_inv` = 1 the whole waveform is inverted and the inactive level is 1.
- R5: With `ld_inv` = 1, every used lane carries the complement of its pixel bit.
- R6: In monochrome mode, lane i (i below the lane count) carries `pix_data` bit i, with lane 0 holding the earliest pixel. All lanes at or above the lane count read 0. In the colour modes all 18 lanes carry `pix_data`.
- R7: `cfg_err` is 1 in any of these cases: a colour mode with `div_sel` < 2 (shift clock faster than one third of the module clock), monochrome with P < 2, or mode code 3. While `cfg_err` is 1, `pix_ready` stays 0 and no word is accepted.
- R8: `ld` changes only at the edge that accepts a word (`pix_valid` and `pix_ready` both high). At that same edge the shift clock goes to its inactive level. Words appear on `ld` in the order they were accepted, one per active shift clock edge.
- R9: If no word is valid in the launch slot, `sclk` rests at its inactive level and `ld` holds its value.
- R10: While reset is asserted, and directly after it, `ld` is all zeros and `sclk` sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 8 | Pixel clock divide field; the pixel clock is the module clock / (div_sel+1) |
| panel_mode | input | 2 | 0 active-matrix colour, 1 passive colour, 2 monochrome, 3 reserved |
| mono_width | input | 2 | Monochrome lane count code: 1, 2, 4 or 8 lanes |
| sclk_inv | input | 1 | Inverts the shift clock |
| ld_inv | input | 1 | Inverts the used data lanes |
| pix_data | input | 18 | Pixel word |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Launch slot open; the word is taken when valid is also high |
| sclk | output | 1 | Panel shift clock |
| ld | output | 18 | Panel data bus |
| cfg_err | output | 1 | Configuration violates the clock limits |

## Verification
Four properties are checked on every cycle: the configuration error blocks the handshake, the data bus holds unless a word is accepted, the bus only moves while the shift clock is inactive, and the idle slot parks the clock. The mode of the bus checked each cycle is also covered: unused monochrome lanes stay zero. The bench scenarios are the only place where the period length for each mode and lane count, the high/low split of each period, both polarities, and the order and content of the launched words (taken through the scoreboard at every active edge) are shown.

// File: rtl/lcd_clk_pkg.sv
package lcd_clk_pkg;
  typedef enum logic [1:0] {
    MODE_TFT  = 2'd0,
    MODE_CSTN = 2'd1,
    MODE_MONO = 2'd2,
    MODE_RSVD = 2'd3
  } panel_mode_e;

  localparam int unsigned MIN_COLOUR_DIV = 2;
endpackage

// File: rtl/lcd_period_calc.sv
module lcd_period_calc
  import lcd_clk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = DIV_W + 4
) (
  input  logic [DIV_W-1:0] div_sel,
  input  logic [1:0]       panel_mode,
  input  logic [1:0]       mono_width,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] half,
  output logic             cfg_err
);
  logic [CNT_W-1:0] base;

  always_comb begin
    base = CNT_W'(div_sel) + CNT_W'(1);
    if (panel_mode == MODE_MONO) period = base << mono_width;
    else                         period = base;
    half = period >> 1;
    case (panel_mode)
      MODE_TFT, MODE_CSTN: cfg_err = (div_sel < DIV_W'(MIN_COLOUR_DIV));
      MODE_MONO:           cfg_err = (period < CNT_W'(2));
      default:             cfg_err = 1'b1;
    endcase
  end
endmodule

// File: rtl/lcd_clk_timer.sv
module lcd_clk_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] half,
  input  logic             cfg_err,
  input  logic             pix_valid,
  output logic             pix_ready,
  output logic             take,
  output logic             sclk_raw
);
  logic [CNT_W-1:0] cnt;
  logic             slot;

  assign slot      = (cnt == '0);
  assign pix_ready = slot & ~cfg_err;
  assign take      = pix_ready & pix_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sclk_raw <= 1'b0;
    end else if (slot) begin
      sclk_raw <= 1'b0;
      if (take) cnt <= CNT_W'(1);
    end else begin
      if (cnt == half) sclk_raw <= 1'b1;
      if (cnt == period - CNT_W'(1)) cnt <= '0;
      else                           cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lcd_data_launch.sv
module lcd_data_launch
  import lcd_clk_pkg::*;
#(
  parameter int LD_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [LD_W-1:0] pix_data,
  input  logic [1:0]      panel_mode,
  input  logic [1:0]      mono_width,
  input  logic            ld_inv,
  output logic [LD_W-1:0] ld
);
  logic [LD_W-1:0] used;

  for (genvar i = 0; i < LD_W; i++) begin : g_lane
    assign used[i] = (panel_mode != MODE_MONO) || (i < (1 << mono_width));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ld <= '0;
    else if (take) ld <= (pix_data ^ {LD_W{ld_inv}}) & used;
  end
endmodule

// File: rtl/lcd_shift_clk_gen.sv
module lcd_shift_clk_gen #(
  parameter int DIV_W = 8,
  parameter int LD_W  = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [1:0]       panel_mode,
  input  logic [1:0]       mono_width,
  input  logic             sclk_inv,
  input  logic             ld_inv,
  input  logic [LD_W-1:0]  pix_data,
  input  logic             pix_valid,
  output logic             pix_ready,
  output logic             sclk,
  output logic [LD_W-1:0]  ld,
  output logic             cfg_err
);
  localparam int CNT_W = DIV_W + 4;

  logic [CNT_W-1:0] period, half;
  logic             take, sclk_raw;

  lcd_period_calc #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_calc (
    .div_sel(div_sel), .panel_mode(panel_mode), .mono_width(mono_width),
    .period(period), .half(half), .cfg_err(cfg_err)
  );

  lcd_clk_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .period(period), .half(half),
    .cfg_err(cfg_err), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .take(take), .sclk_raw(sclk_raw)
  );

  lcd_data_launch #(.LD_W(LD_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .take(take), .pix_data(pix_data),
    .panel_mode(panel_mode), .mono_width(mono_width), .ld_inv(ld_inv),
    .ld(ld)
  );

  assign sclk = sclk_raw ^ sclk_inv;
endmodule

// File: rtl/lcd_clk_chk.sv
module lcd_clk_chk #(
  parameter int LD_W = 18
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      panel_mode,
  input logic [1:0]      mono_width,
  input logic            sclk_inv,
  input logic            pix_valid,
  input logic            pix_ready,
  input logic            sclk,
  input logic [LD_W-1:0] ld,
  input logic            cfg_err
);
  a_r7_err_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !pix_ready);

  a_r8_ld_holds_without_take: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && pix_ready) |=> $stable(ld));

  a_r8_ld_moves_while_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ld) |-> (sclk == sclk_inv));

  a_r9_idle_parks_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> (sclk == sclk_inv));

  a_r6_mono_upper_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (panel_mode == 2'd2) |-> ((ld >> (1 << mono_width)) == '0));
endmodule

bind lcd_shift_clk_gen lcd_clk_chk #(.LD_W(LD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .panel_mode(panel_mode), .mono_width(mono_width),
  .sclk_inv(sclk_inv), .pix_valid(pix_valid), .pix_ready(pix_ready),
  .sclk(sclk), .ld(ld), .cfg_err(cfg_err)
);

// File: tb/lcd_shift_clk_gen_tb.sv
module lcd_shift_clk_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_sel = 8'd3;
  logic [1:0]  panel_mode = 2'd0;
  logic [1:0]  mono_width = 2'd0;
  logic        sclk_inv = 1'b0;
  logic        ld_inv = 1'b0;
  logic [17:0] pix_data = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready, sclk, cfg_err;
  logic [17:0] ld;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  int last_rise = 0;
  int rise_delta = 0;
  int hi_cnt = 0;
  int hi_len = 0;
  logic prev_act = 1'b0;
  logic [17:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcd_shift_clk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .panel_mode(panel_mode),
    .mono_width(mono_width), .sclk_inv(sclk_inv), .ld_inv(ld_inv),
    .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .sclk(sclk), .ld(ld), .cfg_err(cfg_err)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [17:0] lane_mask();
    if (panel_mode == 2'd2) return 18'((1 << (1 << mono_width)) - 1);
    return '1;
  endfunction

  function automatic int exp_period();
    int b = int'(div_sel) + 1;
    if (panel_mode == 2'd2) return b * (1 << mono_width);
    return b;
  endfunction

  // Monitor: scoreboard pops one word per active shift clock edge.
  always @(negedge clk) begin
    logic act;
    if (!rst_n) begin
      prev_act = 1'b0;
      hi_cnt = 0;
    end else begin
      act = sclk ^ sclk_inv;
      if (act && !prev_act) begin
        rise_delta = cyc - last_rise;
        last_rise = cyc;
        if (exp_q.size() == 0) chk("R8 word without launch", 1, 0);
        else chk("R8/R6/R5 ld at active edge", int'(ld), int'(exp_q.pop_front()));
      end
      if (act) hi_cnt++;
      if (!act && prev_act) begin
        hi_len = hi_cnt;
        hi_cnt = 0;
      end
      prev_act = act;
    end
  end

  task automatic apply_cfg(int m, int w, int d, bit si, bit li);
    rst_n = 1'b0;
    pix_valid = 1'b0;
    panel_mode = 2'(m); mono_width = 2'(w); div_sel = 8'(d);
    sclk_inv = si; ld_inv = li;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Driver: offers a word, waits for the launch slot, pushes the expectation.
  task automatic send(logic [17:0] w);
    pix_data = w;
    pix_valid = 1'b1;
    while (!pix_ready) @(negedge clk);
    exp_q.push_back((w & lane_mask()) ^ (ld_inv ? lane_mask() : 18'd0));
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic burst(int n, int seed, string tag);
    int p = exp_period();
    for (int i = 0; i < n; i++) send(18'((i + 1) * 32'h2F5A3 ^ seed));
    repeat (2 * p + 4) @(negedge clk);
    chk({tag, " period"}, rise_delta, p);
    chk("R3 active time", hi_len, p - p / 2);
    chk("R8 all words launched", exp_q.size(), 0);
    chk("R4 idle level", int'(sclk), int'(sclk_inv));
  endtask

  task automatic err_case(int m, int w, int d, string tag);
    int bad = 0;
    apply_cfg(m, w, d, 1'b0, 1'b0);
    chk({tag, " cfg_err set"}, int'(cfg_err), 1);
    pix_valid = 1'b1;
    pix_data = 18'h15555;
    for (int i = 0; i < 20; i++) begin
      if (pix_ready || sclk) bad++;
      @(negedge clk);
    end
    pix_valid = 1'b0;
    chk({tag, " no accept under error"}, bad, 0);
    chk({tag, " ld untouched"}, int'(ld), 0);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [17:0] held;
    // R10: reset state with inverted clock
    apply_cfg(0, 0, 3, 1'b1, 1'b0);
    chk("R10 ld after reset", int'(ld), 0);
    chk("R10 sclk inactive after reset", int'(sclk), 1);
    chk("R7 legal colour config", int'(cfg_err), 0);

    // R1: active-matrix, base 4, inverted clock (R4)
    burst(5, 18'h0, "R1 tft");
    // R9: idle holds bus and clock
    held = ld;
    repeat (12) @(negedge clk);
    chk("R9 ld held when idle", int'(ld), int'(held));
    chk("R9 sclk parked", int'(sclk), 1);

    // R1/R5: passive colour at the limit div 2, data inverted
    apply_cfg(1, 0, 2, 1'b0, 1'b1);
    chk("R7 div 2 is legal", int'(cfg_err), 0);
    burst(6, 18'h3A5C1, "R1 cstn");

    // R2/R6: monochrome widths
    apply_cfg(2, 2, 1, 1'b0, 1'b0);
    burst(4, 18'h12345, "R2 mono x4");
    apply_cfg(2, 3, 0, 1'b1, 1'b1);
    burst(4, 18'h0F0F0, "R2 mono x8");
    apply_cfg(2, 1, 0, 1'b0, 1'b0);
    burst(4, 18'h2AAAA, "R2 mono x2");
    apply_cfg(2, 0, 4, 1'b0, 1'b1);
    burst(3, 18'h3FFFF, "R1 mono x1");

    // R7: illegal configurations
    err_case(0, 0, 1, "R7 tft div1");
    err_case(1, 0, 0, "R7 cstn div0");
    err_case(2, 0, 0, "R7 mono period1");
    err_case(3, 0, 5, "R7 reserved mode");

    finish_run();
  end
endmodule